// File: doc/BRIEF.md
# SMBus host transaction sequencer

This block is an SMBus host controller that software drives through a small byte-wide register port. Software loads a target address, a command code and up to two data bytes, then writes the control register with a transaction type and the start bit set. The block then runs the whole transaction on a byte-level bus engine. It issues start, byte write, byte read (with the ACK or NAK the host returns) and stop operations one at a time, and it takes back the target's ACK for every byte it writes.

Quick, send/receive byte, byte data, word data and process call transactions are supported. Completion is reported through sticky status flags that software clears by writing one to them, and through an optional interrupt line. Software can abort a running transaction with the kill bit. Bit-level line timing, packet error checking and block transfers belong to other blocks.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register, every status flag, `irq_o` and `bus_valid_o` read 0.
- R2: Register offsets: status 0x0, control 0x2, command 0x3, address 0x4, data low 0x5, data high 0x6. Control fields: bit 0 interrupt enable, bit 1 kill, bits 4:2 transaction type (0 quick, 1 byte, 2 byte data, 3 word data, 4 process call), bit 5 last byte, bit 6 start (always reads 0), bit 7 packet-check enable. Status fields: bit 0 busy, bit 1 done, bit 2 device error, bit 3 bus error, bit 4 failed, bit 5 alert. Address register: 7-bit target in bits 7:1 and direction in bit 0 (1 = read).
- R3: Busy reads 1 in the cycle after a start write is accepted. While busy, a start write is ignored and control writes change only the kill bit.
- R4: Bus operations are coded on `bus_op_o` as 0 start, 1 write, 2 read, 3 stop. `bus_valid_o` holds one operation stable until `bus_done_i`. Quick sends start, address, stop. A byte read sends start, address, a read that ends in NAK, then stop. A byte write sends start, address, command, stop.
- R5: Byte-data and word-data writes send start, address, command, the data byte(s), then stop. Their reads send start, the address with bit 0 forced to 0, the command, a repeated start, the address with bit 0 forced to 1, the read(s), then stop. The last read ends in NAK and any earlier read ends in ACK.
- R6: Word transfers put the low byte in data 0 and the high byte in data 1. A write sends data 0 first. A read stores the first byte received in data 0.
- R7: A process call writes the command, data 0 and data 1, then does a repeated-start read of two bytes into data 0 and data 1.
- R8: When a transaction ends, busy clears in the same cycle that exactly one of done, device error, bus error or failed is set.
- R9: A NAK on the address or on any written byte ends the transfer with a stop and sets device error.
- R10: `bus_err_i` on any operation ends the transaction at once, with no stop, and sets bus error.
- R11: Kill while busy lets the operation in flight finish, then sends stop and sets failed. Kill written while idle is ignored and reads back 0.
- R12: Writing 1 to a status flag clears it and writing 0 leaves it unchanged. The alert flag is set while `alert_ni` is low and is cleared the same way.
- R13: `irq_o` is high when interrupt enable is set and any of done, device error, bus error or failed is set.
- R14: Transaction types 5, 6 and 7 end with failed and put nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| alert_ni | input | 1 | Alert line from the bus, active low |
| bus_valid_o | output | 1 | Bus operation request |
| bus_op_o | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| bus_wdata_o | output | 8 | Byte to write |
| bus_nak_o | output | 1 | Host answers the read byte with NAK |
| bus_done_i | input | 1 | Operation finished (one-cycle pulse) |
| bus_ack_i | input | 1 | Target acknowledged the written byte |
| bus_err_i | input | 1 | Bus fault on this operation |
| bus_rdata_i | input | 8 | Byte read from the target |

## Verification
Every transaction type runs against a bus model, and a scoreboard matches the exact stream of operations, bytes and ACK/NAK choices. Byte, word and process-call reads get distinct return bytes, which exposes swapped data registers and any wrong choice between ACK and NAK on the last read. A NAK is injected first on the address and then on a data byte, and a bus fault is injected on the address. These runs separate the stop-then-device-error path from the abort-without-stop path. Kill, a start issued while busy, and unsupported types each check that nothing beyond the expected operations reaches the bus.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned STEP_W = 4;

  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_CTL  = 2;
  localparam int unsigned OFS_CMD  = 3;
  localparam int unsigned OFS_XMIT = 4;
  localparam int unsigned OFS_D0   = 5;
  localparam int unsigned OFS_D1   = 6;

  localparam int unsigned CTL_IEN   = 0;
  localparam int unsigned CTL_KILL  = 1;
  localparam int unsigned CTL_KLO   = 2;
  localparam int unsigned CTL_LAST  = 5;
  localparam int unsigned CTL_START = 6;
  localparam int unsigned CTL_PEC   = 7;

  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_INTR  = 1;
  localparam int unsigned ST_DEV   = 2;
  localparam int unsigned ST_BERR  = 3;
  localparam int unsigned ST_FAIL  = 4;
  localparam int unsigned ST_ALERT = 5;

  typedef enum logic [1:0] {BUS_START, BUS_WRITE, BUS_READ, BUS_STOP} bus_op_e;

  typedef enum logic [3:0] {
    SP_START, SP_ADDR, SP_ADDR_W, SP_ADDR_R, SP_CMD, SP_D0, SP_D1,
    SP_RD0_ACK, SP_RD0_NAK, SP_RD1_NAK, SP_STOP, SP_BAD
  } step_e;

  typedef enum logic [2:0] {
    K_QUICK, K_BYTE, K_BDATA, K_WORD, K_PCALL, K_RSV5, K_RSV6, K_RSV7
  } kind_e;

  typedef enum logic [1:0] {FIN_OK, FIN_DEV, FIN_BUS, FIN_KILL} fin_e;
endpackage

// File: rtl/smb_step_dec.sv
module smb_step_dec
  import smb_host_pkg::*;
(
  input  logic [2:0]        kind_i,
  input  logic              rd_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_e             step_o
);
  always_comb begin
    step_o = SP_BAD;
    unique case (kind_i)
      K_QUICK:
        case (idx_i)
          4'd0: step_o = SP_START;
          4'd1: step_o = SP_ADDR;
          4'd2: step_o = SP_STOP;
          default: step_o = SP_BAD;
        endcase
      K_BYTE:
        case (idx_i)
          4'd0: step_o = SP_START;
          4'd1: step_o = SP_ADDR;
          4'd2: step_o = rd_i ? SP_RD0_NAK : SP_CMD;
          4'd3: step_o = SP_STOP;
          default: step_o = SP_BAD;
        endcase
      K_BDATA:
        if (!rd_i)
          case (idx_i)
            4'd0: step_o = SP_START;
            4'd1: step_o = SP_ADDR;
            4'd2: step_o = SP_CMD;
            4'd3: step_o = SP_D0;
            4'd4: step_o = SP_STOP;
            default: step_o = SP_BAD;
          endcase
        else
          case (idx_i)
            4'd0: step_o = SP_START;
            4'd1: step_o = SP_ADDR_W;
            4'd2: step_o = SP_CMD;
            4'd3: step_o = SP_START;
            4'd4: step_o = SP_ADDR_R;
            4'd5: step_o = SP_RD0_NAK;
            4'd6: step_o = SP_STOP;
            default: step_o = SP_BAD;
          endcase
      K_WORD:
        if (!rd_i)
          case (idx_i)
            4'd0: step_o = SP_START;
            4'd1: step_o = SP_ADDR;
            4'd2: step_o = SP_CMD;
            4'd3: step_o = SP_D0;
            4'd4: step_o = SP_D1;
            4'd5: step_o = SP_STOP;
            default: step_o = SP_BAD;
          endcase
        else
          case (idx_i)
            4'd0: step_o = SP_START;
            4'd1: step_o = SP_ADDR_W;
            4'd2: step_o = SP_CMD;
            4'd3: step_o = SP_START;
            4'd4: step_o = SP_ADDR_R;
            4'd5: step_o = SP_RD0_ACK;
            4'd6: step_o = SP_RD1_NAK;
            4'd7: step_o = SP_STOP;
            default: step_o = SP_BAD;
          endcase
      K_PCALL:
        case (idx_i)
          4'd0: step_o = SP_START;
          4'd1: step_o = SP_ADDR_W;
          4'd2: step_o = SP_CMD;
          4'd3: step_o = SP_D0;
          4'd4: step_o = SP_D1;
          4'd5: step_o = SP_START;
          4'd6: step_o = SP_ADDR_R;
          4'd7: step_o = SP_RD0_ACK;
          4'd8: step_o = SP_RD1_NAK;
          4'd9: step_o = SP_STOP;
          default: step_o = SP_BAD;
        endcase
      default: step_o = SP_BAD;
    endcase
  end
endmodule

// File: rtl/smb_host_fsm.sv
module smb_host_fsm
  import smb_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [2:0]        kind_i,
  input  logic [BYTE_W-1:0] xmit_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] d0_i,
  input  logic [BYTE_W-1:0] d1_i,
  input  logic              kill_i,
  output logic              busy_o,
  output logic              fin_o,
  output fin_e              fin_code_o,
  output logic              rd_we_o,
  output logic              rd_sel_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              bus_valid_o,
  output logic [1:0]        bus_op_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  output logic              bus_nak_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [BYTE_W-1:0] bus_rdata_i
);
  typedef enum logic [1:0] {F_IDLE, F_RUN, F_ABORT} fstate_e;

  fstate_e           state_q;
  logic [STEP_W-1:0] step_q;
  logic              nak_q;
  step_e             dec_step, cur_step;
  logic              is_wr;

  smb_step_dec u_dec (
    .kind_i (kind_i),
    .rd_i   (xmit_i[0]),
    .idx_i  (step_q),
    .step_o (dec_step)
  );

  assign cur_step    = (state_q == F_ABORT) ? SP_STOP : dec_step;
  assign busy_o      = (state_q != F_IDLE);
  assign bus_valid_o = busy_o && (cur_step != SP_BAD);
  assign bus_nak_o   = (cur_step == SP_RD0_NAK) || (cur_step == SP_RD1_NAK);

  always_comb begin
    bus_op_o    = BUS_STOP;
    bus_wdata_o = '0;
    unique case (cur_step)
      SP_START:  bus_op_o = BUS_START;
      SP_ADDR:   begin bus_op_o = BUS_WRITE; bus_wdata_o = xmit_i; end
      SP_ADDR_W: begin bus_op_o = BUS_WRITE; bus_wdata_o = {xmit_i[BYTE_W-1:1], 1'b0}; end
      SP_ADDR_R: begin bus_op_o = BUS_WRITE; bus_wdata_o = {xmit_i[BYTE_W-1:1], 1'b1}; end
      SP_CMD:    begin bus_op_o = BUS_WRITE; bus_wdata_o = cmd_i; end
      SP_D0:     begin bus_op_o = BUS_WRITE; bus_wdata_o = d0_i; end
      SP_D1:     begin bus_op_o = BUS_WRITE; bus_wdata_o = d1_i; end
      SP_RD0_ACK, SP_RD0_NAK, SP_RD1_NAK: bus_op_o = BUS_READ;
      default:   bus_op_o = BUS_STOP;
    endcase
  end

  assign is_wr = (bus_op_o == BUS_WRITE);

  always_comb begin
    fin_o      = 1'b0;
    fin_code_o = FIN_OK;
    if (state_q == F_RUN && dec_step == SP_BAD) begin
      fin_o      = 1'b1;
      fin_code_o = FIN_KILL;
    end else if (bus_valid_o && bus_done_i) begin
      if (bus_err_i) begin
        fin_o      = 1'b1;
        fin_code_o = FIN_BUS;
      end else if (cur_step == SP_STOP) begin
        fin_o      = 1'b1;
        fin_code_o = kill_i ? FIN_KILL : (nak_q ? FIN_DEV : FIN_OK);
      end
    end
  end

  assign rd_we_o   = (state_q == F_RUN) && bus_done_i && !bus_err_i && (bus_op_o == BUS_READ);
  assign rd_sel_o  = (cur_step == SP_RD1_NAK);
  assign rd_data_o = bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      step_q  <= '0;
      nak_q   <= 1'b0;
    end else begin
      unique case (state_q)
        F_IDLE:
          if (go_i) begin
            state_q <= F_RUN;
            step_q  <= '0;
            nak_q   <= 1'b0;
          end
        F_RUN:
          if (fin_o) state_q <= F_IDLE;
          else if (bus_done_i) begin
            if (kill_i) state_q <= F_ABORT;
            else if (is_wr && !bus_ack_i) begin
              nak_q   <= 1'b1;
              state_q <= F_ABORT;
            end else step_q <= step_q + 1'b1;
          end
        F_ABORT:
          if (fin_o) state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end

  // R8
  fin_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
  // R4
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_done_i) |=> (bus_valid_o && $stable(bus_op_o)));
  // R9
  nak_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_done_i && !bus_err_i && bus_op_o == BUS_WRITE && !bus_ack_i)
      |=> (bus_valid_o && bus_op_o == BUS_STOP));
  // R10
  berr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_done_i && bus_err_i) |=> !bus_valid_o);
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              alert_ni,
  input  logic              busy_i,
  input  logic              fin_i,
  input  fin_e              fin_code_i,
  input  logic              rd_we_i,
  input  logic              rd_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              go_o,
  output logic [2:0]        kind_o,
  output logic [BYTE_W-1:0] xmit_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o,
  output logic              kill_o
);
  logic wr_stat, wr_ctl, wr_cmd, wr_xmit, wr_d0, wr_d1;
  logic ien_q, last_q, pec_q, kill_q;
  logic st_intr_q, st_dev_q, st_berr_q, st_fail_q, st_alert_q;
  logic [1:0] alert_sync_q;
  logic [BYTE_W-1:0] clr;

  assign wr_stat = reg_we_i && (reg_addr_i == REG_AW'(OFS_STAT));
  assign wr_ctl  = reg_we_i && (reg_addr_i == REG_AW'(OFS_CTL));
  assign wr_cmd  = reg_we_i && (reg_addr_i == REG_AW'(OFS_CMD));
  assign wr_xmit = reg_we_i && (reg_addr_i == REG_AW'(OFS_XMIT));
  assign wr_d0   = reg_we_i && (reg_addr_i == REG_AW'(OFS_D0));
  assign wr_d1   = reg_we_i && (reg_addr_i == REG_AW'(OFS_D1));
  assign clr     = wr_stat ? reg_wdata_i : '0;

  assign go_o   = wr_ctl && reg_wdata_i[CTL_START] && !busy_i;
  assign kill_o = kill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= 1'b0;
      last_q <= 1'b0;
      pec_q  <= 1'b0;
      kind_o <= '0;
      kill_q <= 1'b0;
      cmd_o  <= '0;
      xmit_o <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else begin
      if (wr_ctl && !busy_i) begin
        ien_q  <= reg_wdata_i[CTL_IEN];
        last_q <= reg_wdata_i[CTL_LAST];
        pec_q  <= reg_wdata_i[CTL_PEC];
        kind_o <= reg_wdata_i[CTL_KLO +: 3];
      end
      if (fin_i) kill_q <= 1'b0;
      else if (wr_ctl && busy_i && reg_wdata_i[CTL_KILL]) kill_q <= 1'b1;
      if (wr_cmd)  cmd_o  <= reg_wdata_i;
      if (wr_xmit) xmit_o <= reg_wdata_i;
      if (rd_we_i && !rd_sel_i) d0_o <= rd_data_i;
      else if (wr_d0) d0_o <= reg_wdata_i;
      if (rd_we_i && rd_sel_i) d1_o <= rd_data_i;
      else if (wr_d1) d1_o <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_sync_q <= 2'b11;
      st_intr_q    <= 1'b0;
      st_dev_q     <= 1'b0;
      st_berr_q    <= 1'b0;
      st_fail_q    <= 1'b0;
      st_alert_q   <= 1'b0;
    end else begin
      alert_sync_q <= {alert_sync_q[0], alert_ni};
      st_intr_q  <= (st_intr_q  & ~clr[ST_INTR])  | (fin_i && fin_code_i == FIN_OK);
      st_dev_q   <= (st_dev_q   & ~clr[ST_DEV])   | (fin_i && fin_code_i == FIN_DEV);
      st_berr_q  <= (st_berr_q  & ~clr[ST_BERR])  | (fin_i && fin_code_i == FIN_BUS);
      st_fail_q  <= (st_fail_q  & ~clr[ST_FAIL])  | (fin_i && fin_code_i == FIN_KILL);
      st_alert_q <= (st_alert_q & ~clr[ST_ALERT]) | !alert_sync_q[1];
    end
  end

  assign irq_o = ien_q && (st_intr_q || st_dev_q || st_berr_q || st_fail_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_AW'(OFS_STAT): reg_rdata_o = {2'b00, st_alert_q, st_fail_q, st_berr_q,
                                        st_dev_q, st_intr_q, busy_i};
      REG_AW'(OFS_CTL):  reg_rdata_o = {pec_q, 1'b0, last_q, kind_o, kill_q, ien_q};
      REG_AW'(OFS_CMD):  reg_rdata_o = cmd_o;
      REG_AW'(OFS_XMIT): reg_rdata_o = xmit_o;
      REG_AW'(OFS_D0):   reg_rdata_o = d0_o;
      REG_AW'(OFS_D1):   reg_rdata_o = d1_o;
      default:           reg_rdata_o = '0;
    endcase
  end

  // R3
  go_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> busy_i);
  // R12
  w1c_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[ST_DEV] && !fin_i) |=> !st_dev_q);
  // R11
  kill_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !kill_q) |=> !kill_q);
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  input  logic              alert_ni,
  output logic              bus_valid_o,
  output logic [1:0]        bus_op_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_nak_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [7:0]        bus_rdata_i
);
  logic              go, busy, fin, kill, rd_we, rd_sel;
  fin_e              fin_code;
  logic [2:0]        kind;
  logic [BYTE_W-1:0] xmit, cmd, d0, d1, rd_data;

  smb_host_regs #(.REG_AW(REG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .alert_ni    (alert_ni),
    .busy_i      (busy),
    .fin_i       (fin),
    .fin_code_i  (fin_code),
    .rd_we_i     (rd_we),
    .rd_sel_i    (rd_sel),
    .rd_data_i   (rd_data),
    .go_o        (go),
    .kind_o      (kind),
    .xmit_o      (xmit),
    .cmd_o       (cmd),
    .d0_o        (d0),
    .d1_o        (d1),
    .kill_o      (kill)
  );

  smb_host_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .kind_i      (kind),
    .xmit_i      (xmit),
    .cmd_i       (cmd),
    .d0_i        (d0),
    .d1_i        (d1),
    .kill_i      (kill),
    .busy_o      (busy),
    .fin_o       (fin),
    .fin_code_o  (fin_code),
    .rd_we_o     (rd_we),
    .rd_sel_o    (rd_sel),
    .rd_data_o   (rd_data),
    .bus_valid_o (bus_valid_o),
    .bus_op_o    (bus_op_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_nak_o   (bus_nak_o),
    .bus_done_i  (bus_done_i),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: tb/smb_host_seq_test.sv
`timescale 1ns/1ps
module smb_host_seq_test;
  localparam logic [3:0] A_STAT = 4'h0, A_CTL = 4'h2, A_CMD = 4'h3,
                         A_XMIT = 4'h4, A_D0 = 4'h5, A_D1 = 4'h6;
  localparam logic [1:0] O_S = 2'd0, O_W = 2'd1, O_R = 2'd2, O_P = 2'd3;

  typedef struct packed {logic [1:0] op; logic [7:0] data; logic nak;} item_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq, alert_n = 1'b1;
  logic       bus_valid, bus_nak;
  logic [1:0] bus_op;
  logic [7:0] bus_wdata;
  logic       bus_done = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
  logic [7:0] bus_rdata = '0;

  item_t exp_q[$];
  int n_chk = 0, n_err = 0;
  int op_cnt = 0, wr_cnt = 0, rd_cnt = 0, nak_idx = -1, berr_idx = -1;
  logic [7:0] rd_bytes [2];
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  smb_host_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq), .alert_ni(alert_n),
    .bus_valid_o(bus_valid), .bus_op_o(bus_op), .bus_wdata_o(bus_wdata), .bus_nak_o(bus_nak),
    .bus_done_i(bus_done), .bus_ack_i(bus_ack), .bus_err_i(bus_err), .bus_rdata_i(bus_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_op(input logic [1:0] op, input logic [7:0] d, input logic nak);
    exp_q.push_back('{op: op, data: d, nak: nak});
  endtask

  // monitor: bus model + scoreboard
  initial begin
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      bus_err  = 1'b0;
      if (bus_valid) begin
        @(negedge clk);
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL %s act=op%0d/%h exp=none", cur_req, bus_op, bus_wdata);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (bus_op !== e.op || (e.op == O_W && bus_wdata !== e.data) ||
              (e.op == O_R && bus_nak !== e.nak)) begin
            n_err++;
            $display("FAIL %s act=op%0d/%h/%b exp=op%0d/%h/%b", cur_req,
                     bus_op, bus_wdata, bus_nak, e.op, e.data, e.nak);
          end
        end
        bus_ack = 1'b1;
        if (bus_op == O_W) begin
          if (wr_cnt == nak_idx) bus_ack = 1'b0;
          wr_cnt++;
        end
        if (bus_op == O_R) begin
          bus_rdata = rd_bytes[rd_cnt % 2];
          rd_cnt++;
        end
        bus_err  = (op_cnt == berr_idx);
        op_cnt++;
        bus_done = 1'b1;
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 500; i++) begin
      reg_read(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic prep(input logic [7:0] xm, input logic [7:0] c,
                      input logic [7:0] a0, input logic [7:0] a1,
                      input int nk, input int be);
    reg_write(A_XMIT, xm);
    reg_write(A_CMD, c);
    reg_write(A_D0, a0);
    reg_write(A_D1, a1);
    reg_write(A_STAT, 8'hFF);
    op_cnt = 0; wr_cnt = 0; rd_cnt = 0; nak_idx = nk; berr_idx = be;
  endtask

  task automatic run(input logic [7:0] ctl);
    reg_write(A_CTL, ctl | 8'h40);
    wait_idle();
    chk(cur_req, 8'(exp_q.size()), 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL R8 act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rd_bytes[0] = 8'h00; rd_bytes[1] = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    cur_req = "R1";
    reg_read(A_STAT, v); chk("R1", v, 8'h00);
    reg_read(A_CTL, v);  chk("R1", v, 8'h00);
    reg_read(A_D0, v);   chk("R1", v, 8'h00);
    chk("R1", {6'd0, irq, bus_valid}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 quick write, R13 irq
    cur_req = "R4";
    prep(8'hA0, 8'h00, 8'h00, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_P, 0, 0);
    run(8'h01);
    reg_read(A_STAT, v); chk("R8", v, 8'h02);
    chk("R13", {7'd0, irq}, 8'h01);
    reg_read(A_CTL, v); chk("R2", v, 8'h01);
    reg_write(A_STAT, 8'h02);
    chk("R13", {7'd0, irq}, 8'h00);

    // R4 byte read
    cur_req = "R4";
    rd_bytes[0] = 8'h5A;
    prep(8'hA1, 8'h00, 8'h00, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA1, 0); expect_op(O_R, 0, 1); expect_op(O_P, 0, 0);
    run(8'h04);
    reg_read(A_D0, v); chk("R4", v, 8'h5A);

    // R3 busy next cycle, start ignored while busy
    cur_req = "R3";
    prep(8'hA0, 8'h33, 8'h00, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h33, 0); expect_op(O_P, 0, 0);
    reg_write(A_CTL, 8'h44);
    reg_read(A_STAT, v); chk("R3", v, 8'h01);
    reg_write(A_CTL, 8'h4C);
    wait_idle();
    chk("R3", 8'(exp_q.size()), 8'h00);
    reg_read(A_CTL, v); chk("R3", v, 8'h04);
    reg_read(A_STAT, v); chk("R3", v, 8'h02);

    // R5 byte data write
    cur_req = "R5";
    prep(8'hA0, 8'h10, 8'hC4, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h10, 0);
    expect_op(O_W, 8'hC4, 0); expect_op(O_P, 0, 0);
    run(8'h08);

    // R5 byte data read
    rd_bytes[0] = 8'h6E;
    prep(8'hA1, 8'h10, 8'h00, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h10, 0);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA1, 0); expect_op(O_R, 0, 1); expect_op(O_P, 0, 0);
    run(8'h08);
    reg_read(A_D0, v); chk("R5", v, 8'h6E);

    // R6 word write then read
    cur_req = "R6";
    prep(8'hA0, 8'h20, 8'h11, 8'h22, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h20, 0);
    expect_op(O_W, 8'h11, 0); expect_op(O_W, 8'h22, 0); expect_op(O_P, 0, 0);
    run(8'h0C);
    rd_bytes[0] = 8'h34; rd_bytes[1] = 8'h12;
    prep(8'hA1, 8'h20, 8'h00, 8'h00, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h20, 0);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA1, 0); expect_op(O_R, 0, 0);
    expect_op(O_R, 0, 1); expect_op(O_P, 0, 0);
    run(8'h0C);
    reg_read(A_D0, v); chk("R6", v, 8'h34);
    reg_read(A_D1, v); chk("R6", v, 8'h12);

    // R7 process call
    cur_req = "R7";
    rd_bytes[0] = 8'h9A; rd_bytes[1] = 8'hBC;
    prep(8'hA1, 8'h30, 8'h78, 8'h56, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h30, 0);
    expect_op(O_W, 8'h78, 0); expect_op(O_W, 8'h56, 0); expect_op(O_S, 0, 0);
    expect_op(O_W, 8'hA1, 0); expect_op(O_R, 0, 0); expect_op(O_R, 0, 1); expect_op(O_P, 0, 0);
    run(8'h10);
    reg_read(A_D0, v); chk("R7", v, 8'h9A);
    reg_read(A_D1, v); chk("R7", v, 8'hBC);
    reg_read(A_STAT, v); chk("R8", v, 8'h02);

    // R9 NAK on address, then on data byte
    cur_req = "R9";
    prep(8'hA0, 8'h20, 8'h11, 8'h22, 0, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_P, 0, 0);
    run(8'h0C);
    reg_read(A_STAT, v); chk("R9", v, 8'h04);
    prep(8'hA0, 8'h20, 8'h11, 8'h22, 2, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_W, 8'h20, 0);
    expect_op(O_W, 8'h11, 0); expect_op(O_P, 0, 0);
    run(8'h0C);
    reg_read(A_STAT, v); chk("R9", v, 8'h04);

    // R10 bus error on address, no stop
    cur_req = "R10";
    prep(8'hA0, 8'h20, 8'h11, 8'h22, -1, 1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0);
    run(8'h0C);
    reg_read(A_STAT, v); chk("R10", v, 8'h08);
    // R12 write 0 keeps, write 1 clears
    reg_write(A_STAT, 8'h00);
    reg_read(A_STAT, v); chk("R12", v, 8'h08);
    reg_write(A_STAT, 8'h08);
    reg_read(A_STAT, v); chk("R12", v, 8'h00);

    // R11 kill during word write
    cur_req = "R11";
    prep(8'hA0, 8'h20, 8'h11, 8'h22, -1, -1);
    expect_op(O_S, 0, 0); expect_op(O_W, 8'hA0, 0); expect_op(O_P, 0, 0);
    reg_write(A_CTL, 8'h4C);
    reg_write(A_CTL, 8'h0E);
    wait_idle();
    chk("R11", 8'(exp_q.size()), 8'h00);
    reg_read(A_STAT, v); chk("R11", v, 8'h10);
    reg_write(A_CTL, 8'h02);
    reg_read(A_CTL, v); chk("R11", v, 8'h00);

    // R14 unsupported type
    cur_req = "R14";
    prep(8'hA0, 8'h00, 8'h00, 8'h00, -1, -1);
    run(8'h14);
    reg_read(A_STAT, v); chk("R14", v, 8'h10);

    // R12 alert flag
    cur_req = "R12";
    reg_write(A_STAT, 8'hFF);
    alert_n = 1'b0;
    repeat (4) @(negedge clk);
    alert_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(A_STAT, v); chk("R12", v, 8'h20);
    reg_write(A_STAT, 8'h20);
    reg_read(A_STAT, v); chk("R12", v, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule